// File: doc/BRIEF.md
# Channel Thermal Protection Controller

This block handles thermal protection and fault reporting for a bank of high-side output channels. Each channel has a command bit from the control interface. Each channel also has two junction comparator flags: one says the junction is above its shutdown threshold, the other says it is below its reset threshold. Two shared case comparator flags do the same for the package case. The block gates each channel's enable from these inputs. It drives an unlatched, active-low common fault output and an active-low case warning. It also produces a one-cycle overtemperature event per channel, which feeds the serial interface's fault latches.

A commanded channel whose junction overheats turns off. It comes back by itself once its junction has cooled below the reset threshold. If the case is too hot, overloaded channels are parked in a hold state. They return only after the case warning has cleared and their own junction is cool, so each channel restarts on its own reset event rather than all together. Channels that never overloaded keep following their commands the whole time. A parity-fail flag from the serial decoder is merged into the common fault.

Top module: `chan_thermal_guard`

## Requirements
- R1: When a channel is enabled and its junction-trip flag is high at a clock edge, its enable output is low from that edge on.
- R2: A channel in junction-off state, with its command still high and the case warning inactive, turns back on at the first edge at which its junction-cool flag is high.
- R3: A channel that is in junction-off state while the case warning is active moves to case-hold. It stays off, whatever its junction-cool flag does, until an edge at which the case warning is inactive and its junction-cool flag is high; from that edge it is on again.
- R4: A channel that is not in junction-off or case-hold state has its enable equal to its command in the same cycle, including while the case warning is active.
- R5: Overloaded channels leave junction-off and case-hold independently, each on the edge at which its own junction-cool flag satisfies R2 or R3.
- R6: The case warning output goes low one edge after case-hot is seen and stays low until an edge with case-cool high and case-hot low; it is then high from that edge. With neither flag high it holds its value, and case-hot wins when both flags are high.
- R7: The fault output is low in any cycle in which a channel is in junction-off or case-hold state, or in which the parity-fail input is high; otherwise it is high. It is not latched.
- R8: A channel in junction-off or case-hold state whose command is low at an edge returns to normal state at that edge, which releases its share of the fault.
- R9: The overtemperature event output of a channel is high for exactly the one cycle after the edge on which that channel entered junction-off. A junction-trip flag on an uncommanded channel has no effect.
- R10: Synchronous reset puts every channel in normal state, releases the case warning and clears all events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | NCH | Per-channel on command |
| j_trip | input | NCH | Junction above shutdown threshold |
| j_cool | input | NCH | Junction below reset threshold |
| case_hot | input | 1 | Case above shutdown limit |
| case_cool | input | 1 | Case below reset limit |
| parity_fail | input | 1 | Frame check failure from the serial decoder |
| ch_en | output | NCH | Gated channel enable |
| fault_n | output | 1 | Common fault, active low, unlatched |
| case_warn_n | output | 1 | Case warning, active low |
| ovt_evt | output | NCH | One-cycle overtemperature event per channel |

## Verification
The checker watches, on every cycle, the properties that depend only on the ports. An enabled channel that trips must be off at the next edge with its event raised. Events last a single cycle and always coincide with a low fault. The case warning follows its set, clear and hold rules. Parity failure pulls the fault low, and the fault is released when all commands have been low for two edges. The longer sequences can only be shown by the bench's scenarios, where its reference model is compared every cycle: the case hold that ignores a cool junction until the warning clears, channels restarting one after another at their own reset events, and healthy channels toggling freely while the case is hot.

// File: rtl/tprot_pkg.sv
package tprot_pkg;

    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_JOFF  = 2'd1,
        CH_CHOLD = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic cmd;
        logic j_trip;
        logic j_cool;
    } ch_in_t;

    // Next state of one channel; case_warn is the registered case warning.
    function automatic ch_state_e ch_next(ch_state_e s, ch_in_t in, logic case_warn);
        ch_state_e n;
        n = s;
        case (s)
            CH_RUN: begin
                if (in.cmd && in.j_trip) n = CH_JOFF;
            end
            CH_JOFF: begin
                if (!in.cmd)           n = CH_RUN;
                else if (case_warn)    n = CH_CHOLD;
                else if (in.j_cool)    n = CH_RUN;
            end
            CH_CHOLD: begin
                if (!in.cmd)                    n = CH_RUN;
                else if (!case_warn && in.j_cool) n = CH_RUN;
            end
            default: n = CH_RUN;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tprot_case_hyst.sv
module tprot_case_hyst (
    input  logic clk,
    input  logic rst,
    input  logic case_hot,
    input  logic case_cool,
    output logic warn
);
    always_ff @(posedge clk) begin
        if (rst)            warn <= 1'b0;
        else if (case_hot)  warn <= 1'b1;
        else if (case_cool) warn <= 1'b0;
    end
endmodule

// File: rtl/tprot_chan.sv
module tprot_chan
    import tprot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ch_in_t in,
    input  logic   case_warn,
    output logic   en,
    output logic   overtemp,
    output logic   evt
);
    ch_state_e st_q, st_d;

    always_comb st_d = ch_next(st_q, in, case_warn);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CH_RUN;
            evt  <= 1'b0;
        end else begin
            st_q <= st_d;
            evt  <= (st_q == CH_RUN) && (st_d == CH_JOFF);
        end
    end

    assign en       = in.cmd && (st_q == CH_RUN);
    assign overtemp = (st_q != CH_RUN);
endmodule

// File: rtl/tprot_fault_merge.sv
module tprot_fault_merge #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] overtemp,
    input  logic           parity_fail,
    output logic           fault_n
);
    assign fault_n = !((|overtemp) || parity_fail);
endmodule

// File: rtl/chan_thermal_guard.sv
module chan_thermal_guard
    import tprot_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmd,
    input  logic [NCH-1:0] j_trip,
    input  logic [NCH-1:0] j_cool,
    input  logic           case_hot,
    input  logic           case_cool,
    input  logic           parity_fail,
    output logic [NCH-1:0] ch_en,
    output logic           fault_n,
    output logic           case_warn_n,
    output logic [NCH-1:0] ovt_evt
);
    logic           warn;
    logic [NCH-1:0] overtemp;

    tprot_case_hyst u_case (
        .clk      (clk),
        .rst      (rst),
        .case_hot (case_hot),
        .case_cool(case_cool),
        .warn     (warn)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_in_t ci;
        assign ci = '{cmd: cmd[i], j_trip: j_trip[i], j_cool: j_cool[i]};
        tprot_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .in       (ci),
            .case_warn(warn),
            .en       (ch_en[i]),
            .overtemp (overtemp[i]),
            .evt      (ovt_evt[i])
        );
    end

    tprot_fault_merge #(.NCH(NCH)) u_fault (
        .overtemp   (overtemp),
        .parity_fail(parity_fail),
        .fault_n    (fault_n)
    );

    assign case_warn_n = !warn;
endmodule

// File: rtl/chan_thermal_guard_chk.sv
module chan_thermal_guard_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] cmd,
    input logic [NCH-1:0] j_trip,
    input logic           case_hot,
    input logic           case_cool,
    input logic           parity_fail,
    input logic [NCH-1:0] ch_en,
    input logic           fault_n,
    input logic           case_warn_n,
    input logic [NCH-1:0] ovt_evt
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_EN_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
            ch_en[i] |-> cmd[i]);                                   // R4
        AST_TRIP_OFF: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && j_trip[i]) |=> (!ch_en[i] && ovt_evt[i])); // R1
        AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
            ovt_evt[i] |=> !ovt_evt[i]);                            // R9
        AST_EVT_FAULT: assert property (@(posedge clk) disable iff (rst)
            ovt_evt[i] |-> !fault_n);                               // R7
        AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (rst)
            !cmd[i] |=> !ovt_evt[i]);                               // R9
    end

    AST_WARN_SET: assert property (@(posedge clk) disable iff (rst)
        case_hot |=> !case_warn_n);                                 // R6
    AST_WARN_CLR: assert property (@(posedge clk) disable iff (rst)
        (case_cool && !case_hot) |=> case_warn_n);                  // R6
    AST_WARN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!case_hot && !case_cool) |=> $stable(case_warn_n));        // R6
    AST_PARITY_FAULT: assert property (@(posedge clk) disable iff (rst)
        parity_fail |-> !fault_n);                                  // R7
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (!parity_fail && cmd == '0 && $past(cmd) == '0) |-> fault_n); // R8
endmodule

bind chan_thermal_guard chan_thermal_guard_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .j_trip     (j_trip),
    .case_hot   (case_hot),
    .case_cool  (case_cool),
    .parity_fail(parity_fail),
    .ch_en      (ch_en),
    .fault_n    (fault_n),
    .case_warn_n(case_warn_n),
    .ovt_evt    (ovt_evt)
);

// File: tb/chan_thermal_guard_tb_top.sv
module chan_thermal_guard_tb_top;
    localparam int NCH = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cmd = '0, j_trip = '0, j_cool = '0;
    logic           case_hot = 1'b0, case_cool = 1'b0, parity_fail = 1'b0;
    logic [NCH-1:0] ch_en, ovt_evt;
    logic           fault_n, case_warn_n;

    int    tests = 0, fails = 0;
    string req = "R10";
    bit    done = 0;

    // reference model: 0 run, 1 junction-off, 2 case-hold
    int m_st[NCH];
    bit m_evt[NCH];
    bit m_warn;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_thermal_guard #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .j_trip(j_trip), .j_cool(j_cool),
        .case_hot(case_hot), .case_cool(case_cool), .parity_fail(parity_fail),
        .ch_en(ch_en), .fault_n(fault_n), .case_warn_n(case_warn_n), .ovt_evt(ovt_evt)
    );

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin m_st[i] = 0; m_evt[i] = 0; end
            m_warn = 0;
            return;
        end
        for (int i = 0; i < NCH; i++) begin
            int n;
            n = m_st[i];
            if (m_st[i] == 0) begin
                if (cmd[i] && j_trip[i]) n = 1;
            end else if (!cmd[i]) n = 0;
            else if (m_st[i] == 1) begin
                if (m_warn) n = 2; else if (j_cool[i]) n = 0;
            end else begin
                if (!m_warn && j_cool[i]) n = 0;
            end
            m_evt[i] = (m_st[i] == 0) && (n == 1);
            m_st[i] = n;
        end
        if (case_hot) m_warn = 1; else if (case_cool) m_warn = 0;
    endtask

    task automatic compare();
        logic [NCH-1:0] e_en, e_evt;
        logic e_fault_n, any;
        any = 0;
        for (int i = 0; i < NCH; i++) begin
            e_en[i]  = cmd[i] && (m_st[i] == 0);
            e_evt[i] = m_evt[i];
            if (m_st[i] != 0) any = 1;
        end
        e_fault_n = !(any || parity_fail);
        tests++;
        if (ch_en !== e_en) begin fails++;
            $display("FAIL %s ch_en actual=%h expected=%h", req, ch_en, e_en); end
        tests++;
        if (ovt_evt !== e_evt) begin fails++;
            $display("FAIL %s ovt_evt actual=%h expected=%h", req, ovt_evt, e_evt); end
        tests++;
        if (fault_n !== e_fault_n) begin fails++;
            $display("FAIL %s fault_n actual=%b expected=%b", req, fault_n, e_fault_n); end
        tests++;
        if (case_warn_n !== !m_warn) begin fails++;
            $display("FAIL %s case_warn_n actual=%b expected=%b", req, case_warn_n, !m_warn); end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        tick(2);
        rst = 1'b0;
        tick(1);                           // R10 reset state

        req = "R4"; cmd = 8'hA5; tick(3);  // plain command pass-through
        cmd = 8'h5A; tick(2);

        // R1 / R9: trip channel 1, then R2 restart on cool
        req = "R1"; cmd = 8'hFF; j_trip[1] = 1; tick(1);
        j_trip[1] = 0; tick(3);
        req = "R2"; j_cool[1] = 1; tick(2); j_cool[1] = 0;

        // R9: trip flag on uncommanded channel ignored
        req = "R9"; cmd = 8'hFD; j_trip[1] = 1; tick(3); j_trip[1] = 0;

        // R3 / R5 / R4: case hold of channels 2 and 3
        req = "R3"; cmd = 8'hFF; j_trip[3:2] = 2'b11; tick(1);
        j_trip[3:2] = 2'b00; case_hot = 1; tick(2);
        j_cool[3:2] = 2'b11; tick(3);      // cool junction ignored while warned
        req = "R4"; cmd[7:4] = 4'h3; tick(2); cmd[7:4] = 4'hC; tick(2); cmd[7:4] = 4'hF;
        req = "R6"; case_hot = 0; tick(3); // warning holds
        req = "R5"; j_cool[3:2] = 2'b01; case_cool = 1; tick(3);
        case_cool = 0; j_cool[3:2] = 2'b11; tick(2); j_cool = '0;

        // R6: hot and cool together, hot wins
        req = "R6"; case_hot = 1; case_cool = 1; tick(2);
        case_hot = 0; tick(2); case_cool = 0;

        // R8: command low releases a tripped channel
        req = "R8"; j_trip[6] = 1; tick(1); j_trip[6] = 0; tick(2);
        cmd[6] = 0; tick(2); cmd[6] = 1;

        // R7: parity fail merged, unlatched
        req = "R7"; parity_fail = 1; tick(2); parity_fail = 0; tick(2);

        // mixed pseudo-random stimulus
        req = "R5";
        begin
            logic [31:0] lf;
            lf = 32'h1ACE_B00C;
            for (int k = 0; k < 600; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                cmd = lf[7:0] | 8'h3C;
                j_trip = lf[15:8] & lf[23:16] & {NCH{lf[3]}};
                j_cool = ~j_trip & lf[31:24];
                case_hot = lf[4] & lf[9] & lf[17];
                case_cool = lf[5] & lf[12];
                parity_fail = lf[6] & lf[13] & lf[27];
                tick(1);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule